// File: doc/BRIEF.md
# Counting Semaphore Cell

This block keeps one 16-bit counting semaphore shared by several requesting threads. The read port carries take requests. A take returns the current count and then decrements it, but only when the count is above zero. The write port carries release requests. A release raises the count and lets waiting requesters go. Each request selects an access view on a 2-bit code. Two views perform semaphore operations: one that stalls a requester on an empty semaphore, and one that never stalls. A third view is a plain access path: a read through it returns the count without changing it, and a write through it is dropped.

A blocking take that finds the count at zero does not return data. The requester is recorded in a blocked mask and receives a one-cycle stall pulse on its own bit. The next release pulses the wake output for every requester in that mask and empties the mask. A woken requester must issue its take again. The block does not choose which woken requester gets the count first. When a take and a release arrive in the same cycle, the release is applied first. All outputs are registered and appear one clock after the request.

Top module: `sem_cell_top`

## Requirements
- R1: After synchronous reset the count is 0 and no requester is blocked. All outputs are low, a plain-view read returns 0, and the first release pulses no wake bit.
- R2: A take (view code 1 or 2) with count C > 0 gives rd_ack=1 and rd_data=C one cycle later, and leaves the count at C-1.
- R3: A non-blocking take (view code 2) at count 0 gives rd_ack=1, rd_data=0 and no stall bit, and the count stays 0.
- R4: A blocking take (view code 1) at count 0 gives rd_ack=0 and sets only stall bit rd_id for one cycle. It adds rd_id to the blocked mask and leaves the count unchanged.
- R5: A release (write with view code 1) raises the count by one, whatever the value on wr_data.
- R6: At count 0xFFFF a release leaves the count at 0xFFFF.
- R7: A release sets wake bits equal to the blocked mask for one cycle and clears the mask, so a second release wakes nobody.
- R8: A release with view code 2 behaves exactly like one with view code 1.
- R9: A write with view code 0 (plain view) does not change the count or the blocked mask.
- R10: A read with view code 0 gives rd_ack=1 and rd_data equal to the count, and leaves the count unchanged.
- R11: With a take and a release in the same cycle, the release is applied first. A blocking take at count 0 then returns 1 with no stall, and the count ends at 0.
- R12: Requests carrying view code 3 have no effect: no acknowledge, and the count and mask are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid | input | 1 | Read request present |
| rd_view | input | 2 | Read view: 0 plain, 1 blocking take, 2 non-blocking take, 3 reserved |
| rd_id | input | ID_W | Requester issuing the read |
| wr_valid | input | 1 | Write request present |
| wr_view | input | 2 | Write view: 0 plain (dropped), 1 or 2 release, 3 reserved |
| wr_data | input | CNT_W | Write data, never used by the count |
| rd_ack | output | 1 | Read data valid |
| rd_data | output | CNT_W | Count seen by the read |
| stall_o | output | NREQ | One-cycle stall pulse for the requester that blocked |
| wake_o | output | NREQ | One-cycle wake pulse for each released requester |

## Verification
The count is driven through several sequences: releases with varied write data, each followed by takes in both views, to separate increment from data capture. A blocking take at zero and a non-blocking take at zero are each run against an empty semaphore, which separates stalling from returning zero. Two requesters block and are released, and then a second release follows. This shows that the wake pattern equals the mask and that the mask is cleared afterwards. A full climb to 0xFFFF tests saturation, and a release that coincides with a blocking take confirms the release is applied first. Writes and reads in the plain and reserved views are each followed by a plain-view read to show that nothing changed.

// File: rtl/sem_cell_pkg.sv
package sem_cell_pkg;
  typedef enum logic [1:0] {
    VIEW_PLAIN = 2'd0,
    VIEW_BLOCK = 2'd1,
    VIEW_TRY   = 2'd2,
    VIEW_RSVD  = 2'd3
  } view_e;
endpackage

// File: rtl/sem_cell_decode.sv
module sem_cell_decode
  import sem_cell_pkg::*;
(
  input  logic       rd_valid,
  input  logic [1:0] rd_view,
  input  logic       wr_valid,
  input  logic [1:0] wr_view,
  output logic       take_en,
  output logic       take_blk,
  output logic       peek_en,
  output logic       rel_en
);
  view_e rv, wv;

  always_comb begin
    rv       = view_e'(rd_view);
    wv       = view_e'(wr_view);
    take_en  = rd_valid && (rv == VIEW_BLOCK || rv == VIEW_TRY);
    take_blk = rv == VIEW_BLOCK;
    peek_en  = rd_valid && (rv == VIEW_PLAIN);
    // plain-view writes and reserved codes fall through as no-ops
    rel_en   = wr_valid && (wv == VIEW_BLOCK || wv == VIEW_TRY);
  end

  // R12: decoded actions never overlap on the read side
  always_comb begin
    peek_take_excl_chk: assert (!(take_en && peek_en));
  end
endmodule

// File: rtl/sem_cell_counter.sv
module sem_cell_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rel_en,
  input  logic             take_en,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_view,
  output logic             cnt_empty
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_d;

  // release is folded in before the take sees the count
  always_comb begin
    cnt_view  = (rel_en && cnt_q != CNT_MAX) ? cnt_q + 1'b1 : cnt_q;
    cnt_empty = (cnt_view == '0);
    cnt_d     = (take_en && !cnt_empty) ? cnt_view - 1'b1 : cnt_view;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  // R6
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (rel_en && !take_en && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
  // R5
  cnt_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (rel_en && !take_en && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R2
  cnt_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (take_en && !rel_en && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (take_en && !rel_en && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/sem_cell_waitmask.sv
module sem_cell_waitmask #(
  parameter int NREQ = 4,
  parameter int ID_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rel_en,
  input  logic            stall_en,
  input  logic [ID_W-1:0] stall_id,
  output logic [NREQ-1:0] stall_o,
  output logic [NREQ-1:0] wake_o
);
  logic [NREQ-1:0] mask_q;

  for (genvar g = 0; g < NREQ; g++) begin : g_req
    logic hit;
    assign hit = stall_en && (stall_id == ID_W'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[g]  <= 1'b0;
        stall_o[g] <= 1'b0;
        wake_o[g]  <= 1'b0;
      end else begin
        mask_q[g]  <= (mask_q[g] && !rel_en) || hit;
        stall_o[g] <= hit;
        wake_o[g]  <= rel_en && mask_q[g];
      end
    end
  end

  // R7
  mask_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rel_en && !stall_en) |=> mask_q == '0);
  // R7
  wake_match_chk: assert property (@(posedge clk) disable iff (rst)
    rel_en |=> wake_o == $past(mask_q));
  // R4
  stall_rec_chk: assert property (@(posedge clk) disable iff (rst)
    stall_en |=> (mask_q[$past(stall_id)] && $onehot0(stall_o) && stall_o != '0));
endmodule

// File: rtl/sem_cell_top.sv
module sem_cell_top #(
  parameter int CNT_W = 16,
  parameter int NREQ  = 4,
  localparam int ID_W = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_valid,
  input  logic [1:0]       rd_view,
  input  logic [ID_W-1:0]  rd_id,
  input  logic             wr_valid,
  input  logic [1:0]       wr_view,
  input  logic [CNT_W-1:0] wr_data,
  output logic             rd_ack,
  output logic [CNT_W-1:0] rd_data,
  output logic [NREQ-1:0]  stall_o,
  output logic [NREQ-1:0]  wake_o
);
  logic take_en, take_blk, peek_en, rel_en;
  logic stall_en, ack_d, cnt_empty;
  logic [CNT_W-1:0] cnt_q, cnt_view;
  logic unused_data;

  assign unused_data = ^wr_data;

  sem_cell_decode u_dec (
    .rd_valid (rd_valid),
    .rd_view  (rd_view),
    .wr_valid (wr_valid),
    .wr_view  (wr_view),
    .take_en  (take_en),
    .take_blk (take_blk),
    .peek_en  (peek_en),
    .rel_en   (rel_en)
  );

  sem_cell_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .rel_en    (rel_en),
    .take_en   (take_en),
    .cnt_q     (cnt_q),
    .cnt_view  (cnt_view),
    .cnt_empty (cnt_empty)
  );

  assign stall_en = take_en && take_blk && cnt_empty;
  assign ack_d    = (take_en && !stall_en) || peek_en;

  sem_cell_waitmask #(.NREQ(NREQ), .ID_W(ID_W)) u_wait (
    .clk      (clk),
    .rst      (rst),
    .rel_en   (rel_en),
    .stall_en (stall_en),
    .stall_id (rd_id),
    .stall_o  (stall_o),
    .wake_o   (wake_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ack  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_ack  <= ack_d;
      rd_data <= ack_d ? cnt_view : '0;
    end
  end

  // R4
  ack_stall_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_ack && stall_o != '0));
  // R10
  peek_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (peek_en && !rel_en) |=> cnt_q == $past(cnt_q));
  // R11
  rel_first_chk: assert property (@(posedge clk) disable iff (rst)
    (rel_en && take_en) |=> (rd_ack && stall_o == '0));
endmodule

// File: tb/sem_cell_top_test.sv
`timescale 1ns/1ps
module sem_cell_top_test;
  localparam int CNT_W = 16;
  localparam int NREQ  = 4;
  localparam int ID_W  = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             rd_valid = 1'b0;
  logic [1:0]       rd_view = 2'd0;
  logic [ID_W-1:0]  rd_id = '0;
  logic             wr_valid = 1'b0;
  logic [1:0]       wr_view = 2'd0;
  logic [CNT_W-1:0] wr_data = '0;
  logic             rd_ack;
  logic [CNT_W-1:0] rd_data;
  logic [NREQ-1:0]  stall_o, wake_o;

  int errors = 0;
  int checks = 0;

  logic             s_ack;
  logic [CNT_W-1:0] s_data;
  logic [NREQ-1:0]  s_stall, s_wake;

  always #2 clk = ~clk;

  sem_cell_top #(.CNT_W(CNT_W), .NREQ(NREQ)) uut (
    .clk(clk), .rst(rst),
    .rd_valid(rd_valid), .rd_view(rd_view), .rd_id(rd_id),
    .wr_valid(wr_valid), .wr_view(wr_view), .wr_data(wr_data),
    .rd_ack(rd_ack), .rd_data(rd_data), .stall_o(stall_o), .wake_o(wake_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one request cycle: drive at negedge, sample 1 ns after the next posedge
  task automatic step(input logic rv, input logic [1:0] rvw, input logic [ID_W-1:0] id,
                      input logic wv, input logic [1:0] wvw, input logic [CNT_W-1:0] wd);
    @(negedge clk);
    rd_valid = rv; rd_view = rvw; rd_id = id;
    wr_valid = wv; wr_view = wvw; wr_data = wd;
    @(posedge clk);
    #1;
    s_ack = rd_ack; s_data = rd_data; s_stall = stall_o; s_wake = wake_o;
    rd_valid = 1'b0; wr_valid = 1'b0;
  endtask

  task automatic peek(output int v);
    step(1'b1, 2'd0, '0, 1'b0, 2'd0, '0);
    v = s_ack ? int'(s_data) : -1;
  endtask

  task automatic release_op(input logic [1:0] vw, input logic [CNT_W-1:0] wd);
    step(1'b0, 2'd0, '0, 1'b1, vw, wd);
  endtask

  task automatic take_op(input logic [1:0] vw, input logic [ID_W-1:0] id);
    step(1'b1, vw, id, 1'b0, 2'd0, '0);
  endtask

  task automatic t_reset();
    int v;
    @(negedge clk);
    chk("R1 ack", rd_ack, 0);
    chk("R1 stall", stall_o, 0);
    chk("R1 wake", wake_o, 0);
    peek(v);
    chk("R1 count", v, 0);
    release_op(2'd1, 16'h0);
    chk("R1 no blocked", s_wake, 0);
    take_op(2'd2, 2'd0);
    chk("R2 take after reset release", s_data, 1);
  endtask

  task automatic t_try_empty();
    int v;
    take_op(2'd2, 2'd1);
    chk("R3 ack", s_ack, 1);
    chk("R3 data", s_data, 0);
    chk("R3 stall", s_stall, 0);
    peek(v);
    chk("R3 count", v, 0);
  endtask

  task automatic t_release_take();
    int v;
    release_op(2'd1, 16'hABCD);
    peek(v);
    chk("R5 inc ignores data", v, 1);
    release_op(2'd2, 16'h1234);
    peek(v);
    chk("R8 try release", v, 2);
    take_op(2'd2, 2'd0);
    chk("R2 ack", s_ack, 1);
    chk("R2 pre value", s_data, 2);
    peek(v);
    chk("R2 decremented", v, 1);
    chk("R10 peek ack", s_ack, 1);
    peek(v);
    chk("R10 peek no change", v, 1);
    take_op(2'd1, 2'd3);
    chk("R2 blocking take", s_data, 1);
    chk("R2 no stall", s_stall, 0);
    peek(v);
    chk("R2 back to zero", v, 0);
  endtask

  task automatic t_plain_rsvd();
    int v;
    release_op(2'd0, 16'h0005);
    peek(v);
    chk("R9 plain write dropped", v, 0);
    release_op(2'd3, 16'h0007);
    peek(v);
    chk("R12 reserved write", v, 0);
    take_op(2'd3, 2'd2);
    chk("R12 reserved read ack", s_ack, 0);
    chk("R12 reserved read stall", s_stall, 0);
  endtask

  task automatic t_block();
    int v;
    take_op(2'd1, 2'd1);
    chk("R4 no ack", s_ack, 0);
    chk("R4 stall id1", s_stall, 4'b0010);
    take_op(2'd1, 2'd3);
    chk("R4 stall id3", s_stall, 4'b1000);
    peek(v);
    chk("R4 count kept", v, 0);
    release_op(2'd0, 16'h0);
    chk("R9 plain write no wake", s_wake, 0);
    release_op(2'd2, 16'hFFFF);
    chk("R7 wake mask", s_wake, 4'b1010);
    release_op(2'd1, 16'h0);
    chk("R7 mask cleared", s_wake, 0);
    peek(v);
    chk("R7 count", v, 2);
    take_op(2'd2, 2'd1);
    take_op(2'd2, 2'd3);
    peek(v);
    chk("R2 drained", v, 0);
  endtask

  task automatic t_same_cycle();
    int v;
    step(1'b1, 2'd1, 2'd2, 1'b1, 2'd1, 16'h0);
    chk("R11 ack", s_ack, 1);
    chk("R11 data", s_data, 1);
    chk("R11 no stall", s_stall, 0);
    peek(v);
    chk("R11 count", v, 0);
  endtask

  task automatic t_saturate();
    int v;
    for (int i = 0; i < 65535; i++) release_op(2'd1, 16'h0);
    peek(v);
    chk("R6 reach max", v, 16'hFFFF);
    release_op(2'd1, 16'h0);
    release_op(2'd2, 16'h0);
    peek(v);
    chk("R6 saturated", v, 16'hFFFF);
    take_op(2'd2, 2'd0);
    chk("R2 take at max", s_data, 16'hFFFF);
    peek(v);
    chk("R2 after max", v, 16'hFFFE);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_try_empty();
    t_release_take();
    t_plain_rsvd();
    t_block();
    t_same_cycle();
    t_saturate();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule